// File: doc/BRIEF.md
# Multi-Source Activity Watchdog Monitor

This block supervises a group of N producers, each of which signals progress by pulsing a raise line or a drop line. A separate check-event pulse cuts time into windows. At every check event the block asks whether the enrolled producers were active in the window that just ended, according to a selectable policy: all of them, at least one of them, or exactly one of them. An enrolment mask leaves sources out of the judgement.

Monitoring starts only when the arm input is held high, and the first check event after arming merely opens the first window. A failed judgement sets a sticky fatal flag. It also freezes a snapshot of the enrolled activity seen in the failing window and the cycle stamp of the last good check event. Together these show when the stall began. Only reset clears the fatal state.

Top module: `wd_activity_monitor`

## Requirements
- R1: While reset is asserted and right after it, fatal_o is 0, fail_snap_o is all zeros and last_good_o is 0.
- R2: A source counts as active in a window if its raise line or its drop line, or both, is high in any cycle of that window. A source with only drop pulses counts the same as one with only raise pulses.
- R3: Check events seen while arm_i is low are ignored. While arm_i is high, the first check event only opens a window and never sets fatal_o, even with no activity.
- R4: With policy_i = 2'b00 (and also with the reserved code 2'b11), a check event fails unless every enrolled source was active in the closing window. An empty enrolment passes.
- R5: With policy_i = 2'b01, a check event fails unless at least one enrolled source was active in the closing window.
- R6: With policy_i = 2'b10, a check event fails unless exactly one enrolled source was active in the closing window. Two or more active sources fail, and so do none.
- R7: A source whose enroll_i bit is 0 plays no part in any policy and never appears in fail_snap_o.
- R8: Activity is cleared at every evaluated check event. Activity in the same cycle as a check event belongs to the window that the event opens.
- R9: After a failure, fatal_o stays 1 until reset. fail_snap_o holds the enrolled activity of the failing window (bit i = source i). Neither output changes again, whatever arm_i and chk_i do.
- R10: last_good_o holds the stamp of the most recent opening or passing check event. The stamp is the number of clock edges between the release of reset and that event's edge, so the first edge after release has stamp 0.
- R11: Dropping arm_i before a failure returns the block to idle and discards activity. After re-arming, the next check event is an opening event again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Level enable for monitoring |
| policy_i | input | 2 | 00 all, 01 any, 10 exactly one, 11 treated as all |
| enroll_i | input | N | Per-source enrolment mask |
| raise_i | input | N | Per-source raise activity pulses |
| drop_i | input | N | Per-source drop activity pulses |
| chk_i | input | 1 | Check-event pulse closing a window |
| fatal_o | output | 1 | Sticky failure flag |
| fail_snap_o | output | N | Enrolled activity of the failing window |
| last_good_o | output | CW | Cycle stamp of the last opening or passing check event |

## Verification
A corrupted activity record stays hidden until the next check event. It then shows in the same cycle as a wrong pass or fail decision, and after a failure as a wrong fail_snap_o. A wrong state, for example skipping the opening event or missing a disarm, shows at the first check event as a spurious fatal_o or a last_good_o stamp that moves when it should not. A cycle counter that is off by even one cycle shows in last_good_o at the first opening event. The bench compares all three outputs against a reference model after every cycle, so each of these faults is reported at the first check event that exposes it.

// File: rtl/wd_pkg.sv
package wd_pkg;

    typedef enum logic [1:0] {
        POL_ALL = 2'b00,
        POL_ANY = 2'b01,
        POL_ONE = 2'b10,
        POL_RSV = 2'b11
    } policy_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_PRIMED = 2'b01,
        ST_WATCH  = 2'b10,
        ST_FAILED = 2'b11
    } wd_state_e;

endpackage

// File: rtl/wd_act_latch.sv
module wd_act_latch #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         collect_i,
    input  logic         restart_i,
    input  logic [N-1:0] raise_i,
    input  logic [N-1:0] drop_i,
    output logic [N-1:0] seen_o
);

    for (genvar g = 0; g < N; g++) begin : g_src
        logic pulse;
        logic seen_d;
        logic seen_q;

        // A raise and a drop both count as activity for this source.
        assign pulse = raise_i[g] | drop_i[g];

        always_comb begin
            if (!collect_i) begin
                seen_d = 1'b0;
            end else if (restart_i) begin
                seen_d = pulse;
            end else begin
                seen_d = seen_q | pulse;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seen_q <= 1'b0;
            end else begin
                seen_q <= seen_d;
            end
        end

        assign seen_o[g] = seen_q;
    end

endmodule

// File: rtl/wd_policy_judge.sv
module wd_policy_judge
    import wd_pkg::*;
#(
    parameter int N = 6
) (
    input  logic [1:0]   policy_i,
    input  logic [N-1:0] enroll_i,
    input  logic [N-1:0] seen_i,
    output logic [N-1:0] hits_o,
    output logic         pass_o
);

    localparam int CNT_W = $clog2(N + 1);

    logic [CNT_W-1:0] hit_cnt;

    assign hits_o = seen_i & enroll_i;

    always_comb begin
        hit_cnt = '0;
        for (int i = 0; i < N; i++) begin
            hit_cnt = hit_cnt + CNT_W'(hits_o[i]);
        end
    end

    always_comb begin
        case (policy_e'(policy_i))
            POL_ANY: pass_o = (hit_cnt != '0);
            POL_ONE: pass_o = (hit_cnt == CNT_W'(1));
            default: pass_o = (hits_o == enroll_i);
        endcase
    end

endmodule

// File: rtl/wd_activity_monitor.sv
module wd_activity_monitor
    import wd_pkg::*;
#(
    parameter int N  = 6,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic [1:0]    policy_i,
    input  logic [N-1:0]  enroll_i,
    input  logic [N-1:0]  raise_i,
    input  logic [N-1:0]  drop_i,
    input  logic          chk_i,
    output logic          fatal_o,
    output logic [N-1:0]  fail_snap_o,
    output logic [CW-1:0] last_good_o
);

    typedef struct packed {
        wd_state_e     state;
        logic          fatal;
        logic [N-1:0]  snap;
        logic [CW-1:0] last_good;
        logic [CW-1:0] cyc;
    } mon_regs_t;

    mon_regs_t    r_d;
    mon_regs_t    r_q;
    logic [N-1:0] seen;
    logic [N-1:0] hits;
    logic         pass;
    logic         collect;
    logic         restart;

    wd_act_latch #(.N(N)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .collect_i (collect),
        .restart_i (restart),
        .raise_i   (raise_i),
        .drop_i    (drop_i),
        .seen_o    (seen)
    );

    wd_policy_judge #(.N(N)) u_judge (
        .policy_i (policy_i),
        .enroll_i (enroll_i),
        .seen_i   (seen),
        .hits_o   (hits),
        .pass_o   (pass)
    );

    always_comb begin
        r_d     = r_q;
        r_d.cyc = r_q.cyc + CW'(1);
        case (r_q.state)
            ST_IDLE: begin
                if (arm_i) begin
                    r_d.state = ST_PRIMED;
                end
            end
            ST_PRIMED: begin
                if (!arm_i) begin
                    r_d.state = ST_IDLE;
                end else if (chk_i) begin
                    r_d.state     = ST_WATCH;
                    r_d.last_good = r_q.cyc;
                end
            end
            ST_WATCH: begin
                if (!arm_i) begin
                    r_d.state = ST_IDLE;
                end else if (chk_i) begin
                    if (pass) begin
                        r_d.last_good = r_q.cyc;
                    end else begin
                        r_d.state = ST_FAILED;
                        r_d.fatal = 1'b1;
                        r_d.snap  = hits;
                    end
                end
            end
            default: begin
                r_d.state = ST_FAILED;
            end
        endcase
    end

    // The window record keeps gathering only while the next state watches.
    assign collect = (r_d.state == ST_WATCH);
    assign restart = chk_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, fatal: 1'b0, snap: '0, last_good: '0, cyc: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign fatal_o     = r_q.fatal;
    assign fail_snap_o = r_q.snap;
    assign last_good_o = r_q.last_good;

endmodule

// File: rtl/wd_activity_monitor_chk.sv
module wd_activity_monitor_chk #(
    parameter int N  = 6,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm_i,
    input logic          chk_i,
    input logic [N-1:0]  enroll_i,
    input logic          fatal_o,
    input logic [N-1:0]  fail_snap_o,
    input logic [CW-1:0] last_good_o
);

    AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |=> fatal_o); // R9

    AST_FROZEN_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |=> ($stable(fail_snap_o) && $stable(last_good_o))); // R9

    AST_FAIL_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fatal_o) |-> $past(chk_i)); // R3

    AST_FAIL_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fatal_o) |-> $past(arm_i)); // R3

    AST_SNAP_ENROLLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fatal_o) |-> ((fail_snap_o & ~$past(enroll_i)) == '0)); // R7

    AST_STAMP_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_i |=> $stable(last_good_o)); // R10

endmodule

bind wd_activity_monitor wd_activity_monitor_chk #(.N(N), .CW(CW)) u_chk (.*);

// File: tb/wd_activity_monitor_test.sv
module wd_activity_monitor_test;

    localparam int N  = 6;
    localparam int CW = 16;
    localparam logic [N-1:0] ALLS = {N{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm_i = 1'b0;
    logic [1:0]    policy_i = 2'b00;
    logic [N-1:0]  enroll_i = '0;
    logic [N-1:0]  raise_i = '0;
    logic [N-1:0]  drop_i = '0;
    logic          chk_i = 1'b0;
    logic          fatal_o;
    logic [N-1:0]  fail_snap_o;
    logic [CW-1:0] last_good_o;

    int checks = 0;
    int errors = 0;
    int ncyc = 0;

    int            m_st;
    logic [N-1:0]  m_seen;
    logic          m_fatal;
    logic [N-1:0]  m_snap;
    logic [CW-1:0] m_lg;

    always #2.5 clk = ~clk;

    wd_activity_monitor #(.N(N), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .policy_i(policy_i),
        .enroll_i(enroll_i), .raise_i(raise_i), .drop_i(drop_i), .chk_i(chk_i),
        .fatal_o(fatal_o), .fail_snap_o(fail_snap_o), .last_good_o(last_good_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit judge(input logic [1:0] pol, input logic [N-1:0] seen,
                                 input logic [N-1:0] enr);
        logic [N-1:0] h;
        int c;
        h = seen & enr;
        c = 0;
        for (int i = 0; i < N; i++) c += int'(h[i]);
        case (pol)
            2'b01:   return c > 0;
            2'b10:   return c == 1;
            default: return h == enr;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        arm_i = 1'b0; chk_i = 1'b0; raise_i = '0; drop_i = '0;
        repeat (2) @(negedge clk);
        check("R1 fatal", 32'(fatal_o), 0);
        check("R1 snap", 32'(fail_snap_o), 0);
        check("R1 stamp", 32'(last_good_o), 0);
        rst_n = 1'b1;
        ncyc = 0;
        m_st = 0; m_seen = '0; m_fatal = 1'b0; m_snap = '0; m_lg = '0;
    endtask

    // Drive at the falling edge, update the model at the rising edge,
    // compare at the next falling edge.
    task automatic step(input bit arm, input logic [1:0] pol, input logic [N-1:0] enr,
                        input logic [N-1:0] rse, input logic [N-1:0] drp, input bit chk);
        logic [N-1:0] act;
        arm_i = arm; policy_i = pol; enroll_i = enr;
        raise_i = rse; drop_i = drp; chk_i = chk;
        act = rse | drp;
        @(posedge clk);
        case (m_st)
            0: begin m_seen = '0; if (arm) m_st = 1; end
            1: begin
                if (!arm) begin m_st = 0; m_seen = '0; end
                else if (chk) begin m_st = 2; m_seen = act; m_lg = CW'(ncyc); end
                else m_seen = '0;
            end
            2: begin
                if (!arm) begin m_st = 0; m_seen = '0; end
                else if (chk) begin
                    if (judge(pol, m_seen, enr)) begin
                        m_lg = CW'(ncyc); m_seen = act;
                    end else begin
                        m_st = 3; m_fatal = 1'b1; m_snap = m_seen & enr; m_seen = '0;
                    end
                end else m_seen = m_seen | act;
            end
            default: ;
        endcase
        ncyc++;
        @(negedge clk);
        check("R9 fatal vs model", 32'(fatal_o), 32'(m_fatal));
        check("R9 snap vs model", 32'(fail_snap_o), 32'(m_snap));
        check("R10 stamp vs model", 32'(last_good_o), 32'(m_lg));
    endtask

    task automatic idle(input bit arm, input logic [1:0] pol, input logic [N-1:0] enr);
        step(arm, pol, enr, '0, '0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual hung, expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s;
        void'($urandom(32'd5150));

        // R3 and R10: events before arming ignored, first armed event opens
        do_reset();
        step(0, 2'b01, ALLS, '0, '0, 1);
        step(0, 2'b01, ALLS, '0, '0, 1);
        check("R3 ignored before arm", 32'(fatal_o), 0);
        check("R3 stamp untouched", 32'(last_good_o), 0);
        idle(1, 2'b01, ALLS);
        s = ncyc;
        step(1, 2'b01, ALLS, '0, '0, 1);
        check("R3 opening event no fail", 32'(fatal_o), 0);
        check("R10 opening stamp", 32'(last_good_o), 32'(s));

        // R4 and R2: all policy, raise and drop both count
        step(1, 2'b00, ALLS, 6'h07, '0, 0);
        step(1, 2'b00, ALLS, '0, 6'h38, 0);
        s = ncyc;
        step(1, 2'b00, ALLS, '0, '0, 1);
        check("R2 mixed raise drop pass", 32'(fatal_o), 0);
        check("R10 pass stamp", 32'(last_good_o), 32'(s));
        step(1, 2'b00, ALLS, 6'h0F, 6'h10, 0);
        step(1, 2'b00, ALLS, '0, '0, 1);
        check("R4 missing source fails", 32'(fatal_o), 1);
        check("R9 snap of failing window", 32'(fail_snap_o), 32'h1F);
        step(0, 2'b00, ALLS, ALLS, '0, 1);
        step(1, 2'b01, ALLS, ALLS, '0, 1);
        step(1, 2'b01, ALLS, '0, '0, 1);
        check("R9 fatal sticky", 32'(fatal_o), 1);
        check("R9 snap frozen", 32'(fail_snap_o), 32'h1F);
        check("R9 stamp frozen", 32'(last_good_o), 32'(s));

        // R5: any policy
        do_reset();
        idle(1, 2'b01, ALLS);
        step(1, 2'b01, ALLS, '0, '0, 1);
        step(1, 2'b01, ALLS, '0, 6'h04, 0);
        step(1, 2'b01, ALLS, '0, '0, 1);
        check("R5 one active passes", 32'(fatal_o), 0);
        idle(1, 2'b01, ALLS);
        step(1, 2'b01, ALLS, '0, '0, 1);
        check("R5 silent window fails", 32'(fatal_o), 1);
        check("R5 snap empty", 32'(fail_snap_o), 0);

        // R6: exactly one policy
        do_reset();
        idle(1, 2'b10, ALLS);
        step(1, 2'b10, ALLS, '0, '0, 1);
        step(1, 2'b10, ALLS, 6'h20, '0, 0);
        step(1, 2'b10, ALLS, '0, 6'h20, 0);
        step(1, 2'b10, ALLS, '0, '0, 1);
        check("R6 single source passes", 32'(fatal_o), 0);
        step(1, 2'b10, ALLS, 6'h02, '0, 0);
        step(1, 2'b10, ALLS, 6'h08, '0, 0);
        step(1, 2'b10, ALLS, '0, '0, 1);
        check("R6 two sources fail", 32'(fatal_o), 1);
        check("R6 snap", 32'(fail_snap_o), 32'h0A);

        // R7: enrolment mask
        do_reset();
        idle(1, 2'b00, 6'h05);
        step(1, 2'b00, 6'h05, '0, '0, 1);
        step(1, 2'b00, 6'h05, 6'h07, '0, 0);
        step(1, 2'b00, 6'h05, '0, '0, 1);
        check("R7 unenrolled ignored pass", 32'(fatal_o), 0);
        step(1, 2'b00, 6'h05, 6'h3B, '0, 0);
        step(1, 2'b00, 6'h05, '0, '0, 1);
        check("R7 fail despite unenrolled activity", 32'(fatal_o), 1);
        check("R7 snap excludes unenrolled", 32'(fail_snap_o), 32'h01);

        // R4 and R7: empty enrolment
        do_reset();
        idle(1, 2'b00, '0);
        step(1, 2'b00, '0, '0, '0, 1);
        step(1, 2'b00, '0, ALLS, '0, 1);
        check("R4 empty enrolment passes", 32'(fatal_o), 0);
        step(1, 2'b01, '0, ALLS, '0, 1);
        check("R7 empty enrolment any fails", 32'(fatal_o), 1);

        // R8: same-cycle activity goes to the next window
        do_reset();
        idle(1, 2'b00, 6'h01);
        step(1, 2'b00, 6'h01, '0, '0, 1);
        step(1, 2'b00, 6'h01, 6'h01, '0, 0);
        step(1, 2'b00, 6'h01, 6'h01, '0, 1);
        idle(1, 2'b00, 6'h01);
        step(1, 2'b00, 6'h01, '0, '0, 1);
        check("R8 same-cycle activity carried", 32'(fatal_o), 0);
        idle(1, 2'b00, 6'h01);
        step(1, 2'b00, 6'h01, '0, '0, 1);
        check("R8 window cleared after event", 32'(fatal_o), 1);

        // R11: disarm discards and re-opens
        do_reset();
        idle(1, 2'b01, ALLS);
        step(1, 2'b01, ALLS, '0, '0, 1);
        step(0, 2'b01, ALLS, ALLS, '0, 1);
        idle(1, 2'b01, ALLS);
        s = ncyc;
        step(1, 2'b01, ALLS, '0, '0, 1);
        check("R11 re-arm opens again", 32'(fatal_o), 0);
        check("R11 reopen stamp", 32'(last_good_o), 32'(s));
        step(1, 2'b01, ALLS, '0, '0, 1);
        check("R11 discarded activity", 32'(fatal_o), 1);

        // R4: reserved code behaves as all
        do_reset();
        idle(1, 2'b11, ALLS);
        step(1, 2'b11, ALLS, '0, '0, 1);
        step(1, 2'b11, ALLS, 6'h3E, '0, 0);
        step(1, 2'b11, ALLS, '0, '0, 1);
        check("R4 reserved policy as all", 32'(fatal_o), 1);
        check("R4 reserved snap", 32'(fail_snap_o), 32'h3E);

        // Random episodes, compared each cycle against the model (R2 R4 R5 R6 R9 R10)
        for (int ep = 0; ep < 40; ep++) begin
            logic [1:0]   pol;
            logic [N-1:0] enr;
            do_reset();
            pol = 2'($urandom_range(0, 3));
            enr = N'($urandom);
            for (int c = 0; c < 300; c++) begin
                bit arm;
                bit chk;
                logic [N-1:0] rse;
                logic [N-1:0] drp;
                arm = ($urandom_range(0, 49) != 0);
                chk = ($urandom_range(0, 5) == 0);
                rse = N'($urandom) & N'($urandom) & N'($urandom);
                drp = N'($urandom) & N'($urandom) & N'($urandom);
                if ($urandom_range(0, 19) == 0) pol = 2'($urandom_range(0, 3));
                step(arm, pol, enr, rse, drp, chk);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule